// File: doc/BRIEF.md
# Reset-Configured Bus-Width Matcher with Selectable Sub-Word Order

This block sits between a pair of narrow or wide data ports and a store that holds 36-bit words. On the write side it gathers 18-bit or 9-bit sub-words into full 36-bit words before handing them to the store. On the read side it takes 36-bit words from the store and hands them out as 18-bit or 9-bit sub-words. When both sides are 36 bits wide, words pass straight through.

Four strap inputs are sampled while reset is high and then held. Three of them pick one of five width pairings. The fourth picks the sub-word order: either the most significant portion of a long word travels first, or the least significant one does. Every side uses a valid/ready handshake, and one word moves per clock at most.

Top module: `bmx_width_conv`

## Requirements
- R1: With `cfg_bus_match` low, both sides are 36 bits wide, whatever the other two width straps are. With it high, {`cfg_in_narrow`,`cfg_out_narrow`} = 00 gives 36 in / 18 out, 01 gives 36 in / 9 out, 10 gives 18 in / 36 out and 11 gives 9 in / 36 out.
- R2: The four straps are sampled only while `rst` is high. Later changes on them have no effect on widths or order.
- R3: On the write side, one 36-bit word is offered on `st_wr_*` for every 2 (18-bit input) or 4 (9-bit input) accepted sub-words. It is offered only after the last sub-word of the group has been accepted.
- R4: On the read side, each 36-bit word accepted from `st_rd_*` is delivered as 2 (18-bit output) or 4 (9-bit output) sub-words. `st_rd_ready` rises for the next word only once the last sub-word of the current one is being accepted.
- R5: With `cfg_lsb_first` low at reset, the sub-word that travels first occupies the most significant lane. With it high, the first one occupies the least significant lane. The 18-bit lanes are bits 35:18 and 17:0. The 9-bit lanes are bits 35:27, 26:18, 17:9 and 8:0.
- R6: A narrow input sub-word is taken from `in_data` bits [w-1:0], where w is 18 or 9. The upper input bits are ignored.
- R7: A narrow output sub-word appears on `out_data` bits [w-1:0], and the bits above it are driven to zero.
- R8: While `st_wr_valid` or `out_valid` is high and its ready is low, the valid signal stays high and its data stays unchanged.
- R9: Reset clears `st_wr_valid` and `out_valid`, and it discards any partly gathered write word.
- R10: In the 36/36 pairing, each accepted input word appears unchanged on `st_wr_data`, and each store word appears unchanged on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| cfg_bus_match | input | 1 | Width strap: enables narrow pairings |
| cfg_in_narrow | input | 1 | Width strap: narrow write side |
| cfg_out_narrow | input | 1 | Width strap: 9-bit (vs 18-bit) variant |
| cfg_lsb_first | input | 1 | Order strap: 0 = most significant first, 1 = least significant first |
| in_valid | input | 1 | Input sub-word valid |
| in_ready | output | 1 | Input sub-word accepted when high with in_valid |
| in_data | input | 36 | Input sub-word (low bits used in narrow modes) |
| st_wr_valid | output | 1 | Packed word offered to the store |
| st_wr_ready | input | 1 | Store accepts packed word |
| st_wr_data | output | 36 | Packed word |
| st_rd_valid | input | 1 | Store offers a word |
| st_rd_ready | output | 1 | Block takes the offered store word |
| st_rd_data | input | 36 | Word from the store |
| out_valid | output | 1 | Output sub-word valid |
| out_ready | input | 1 | Consumer accepts output sub-word |
| out_data | output | 36 | Output sub-word, zero-extended in narrow modes |

## Verification
The assertions assume that the strap inputs hold steady for the whole reset pulse. They also assume that a producer does not drop valid or change data between offering a word and seeing it accepted. The bench drives every input just after a rising edge and keeps each offer in place until it sees ready. It changes the straps only after reset has been released, and only to scramble them on purpose. Ready on both consumer sides follows fixed periodic patterns, so stalls land on every sub-word position. The packed and unpacked words are computed from the sub-word index and the lane arithmetic.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    localparam int WORD_W    = 36;
    localparam int MAX_LANES = 4;
    localparam int IDX_W     = $clog2(MAX_LANES);
    localparam int CNT_W     = IDX_W + 1;

    typedef enum logic [2:0] {
        MODE_FULL    = 3'd0,
        MODE_W36_R18 = 3'd1,
        MODE_W36_R9  = 3'd2,
        MODE_W18_R36 = 3'd3,
        MODE_W9_R36  = 3'd4
    } bmx_mode_e;

    typedef struct packed {
        bmx_mode_e mode;
        logic      lsb_first;
    } bmx_cfg_t;

    function automatic bmx_mode_e decode_mode(logic bm, logic iw, logic ow);
        if (!bm) return MODE_FULL;
        case ({iw, ow})
            2'b00:   return MODE_W36_R18;
            2'b01:   return MODE_W36_R9;
            2'b10:   return MODE_W18_R36;
            default: return MODE_W9_R36;
        endcase
    endfunction

    // number of sub-words per stored word on the write side
    function automatic logic [CNT_W-1:0] lanes_in(bmx_mode_e m);
        case (m)
            MODE_W18_R36: return CNT_W'(2);
            MODE_W9_R36:  return CNT_W'(4);
            default:      return CNT_W'(1);
        endcase
    endfunction

    // number of sub-words per stored word on the read side
    function automatic logic [CNT_W-1:0] lanes_out(bmx_mode_e m);
        case (m)
            MODE_W36_R18: return CNT_W'(2);
            MODE_W36_R9:  return CNT_W'(4);
            default:      return CNT_W'(1);
        endcase
    endfunction

    function automatic int sub_width(logic [CNT_W-1:0] n);
        int d;
        d = (n == '0) ? 1 : int'(n);
        return WORD_W / d;
    endfunction

    // physical lane for the idx-th sub-word in transfer order
    function automatic logic [IDX_W-1:0] lane_for(logic [IDX_W-1:0] idx,
                                                  logic [CNT_W-1:0] n,
                                                  logic             lsb_first);
        logic [CNT_W-1:0] t;
        t = lsb_first ? {1'b0, idx} : (n - CNT_W'(1) - {1'b0, idx});
        return t[IDX_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(logic [CNT_W-1:0] n,
                                                    logic [IDX_W-1:0] lane);
        int w;
        logic [WORD_W-1:0] ones;
        w    = sub_width(n);
        ones = {WORD_W{1'b1}} >> (WORD_W - w);
        return ones << (int'(lane) * w);
    endfunction

    function automatic logic [WORD_W-1:0] insert_lane(logic [WORD_W-1:0] word,
                                                      logic [WORD_W-1:0] sub,
                                                      logic [CNT_W-1:0]  n,
                                                      logic [IDX_W-1:0]  lane);
        logic [WORD_W-1:0] m;
        m = lane_mask(n, lane);
        return (word & ~m) | ((sub << (int'(lane) * sub_width(n))) & m);
    endfunction

    function automatic logic [WORD_W-1:0] extract_lane(logic [WORD_W-1:0] word,
                                                       logic [CNT_W-1:0]  n,
                                                       logic [IDX_W-1:0]  lane);
        return (word & lane_mask(n, lane)) >> (int'(lane) * sub_width(n));
    endfunction

endpackage

// File: rtl/bmx_cfg_latch.sv
module bmx_cfg_latch
    import bmx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_bm,
    input  logic     pin_iw,
    input  logic     pin_ow,
    input  logic     pin_lsb,
    output bmx_cfg_t cfg
);

    bmx_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode      <= decode_mode(pin_bm, pin_iw, pin_ow);
            cfg_q.lsb_first <= pin_lsb;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/bmx_packer.sv
module bmx_packer
    import bmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bmx_cfg_t          cfg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [WORD_W-1:0] pk_data
);

    logic [WORD_W-1:0] acc_q, word_q, merged;
    logic [IDX_W-1:0]  idx_q, lane;
    logic [CNT_W-1:0]  n;
    logic              vld_q, last, take;

    always_comb begin
        n      = lanes_in(cfg.mode);
        lane   = lane_for(idx_q, n, cfg.lsb_first);
        merged = insert_lane(acc_q, in_data, n, lane);
        last   = ({1'b0, idx_q} == (n - CNT_W'(1)));
    end

    assign in_ready = !vld_q || pk_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            word_q <= '0;
            idx_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            if (vld_q && pk_ready) vld_q <= 1'b0;
            if (take) begin
                if (last) begin
                    word_q <= merged;
                    vld_q  <= 1'b1;
                    acc_q  <= '0;
                    idx_q  <= '0;
                end else begin
                    acc_q <= merged;
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    assign pk_valid = vld_q;
    assign pk_data  = word_q;

endmodule

// File: rtl/bmx_unpacker.sv
module bmx_unpacker
    import bmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bmx_cfg_t          cfg,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [WORD_W-1:0] src_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    logic [WORD_W-1:0] hold_q;
    logic [IDX_W-1:0]  idx_q, lane;
    logic [CNT_W-1:0]  n;
    logic              hold_vld_q, last, give, fetch;

    always_comb begin
        n    = lanes_out(cfg.mode);
        lane = lane_for(idx_q, n, cfg.lsb_first);
        last = ({1'b0, idx_q} == (n - CNT_W'(1)));
    end

    assign give      = hold_vld_q && out_ready;
    assign src_ready = !hold_vld_q || (out_ready && last);
    assign fetch     = src_valid && src_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            idx_q      <= '0;
        end else begin
            if (give) begin
                if (last) begin
                    hold_vld_q <= 1'b0;
                    idx_q      <= '0;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
            if (fetch) begin
                hold_q     <= src_data;
                hold_vld_q <= 1'b1;
                idx_q      <= '0;
            end
        end
    end

    assign out_valid = hold_vld_q;
    assign out_data  = extract_lane(hold_q, n, lane);

endmodule

// File: rtl/bmx_width_conv.sv
module bmx_width_conv
    import bmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bus_match,
    input  logic              cfg_in_narrow,
    input  logic              cfg_out_narrow,
    input  logic              cfg_lsb_first,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              st_wr_valid,
    input  logic              st_wr_ready,
    output logic [WORD_W-1:0] st_wr_data,
    input  logic              st_rd_valid,
    output logic              st_rd_ready,
    input  logic [WORD_W-1:0] st_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    bmx_cfg_t cfg;

    bmx_cfg_latch u_cfg (
        .clk     (clk),
        .rst     (rst),
        .pin_bm  (cfg_bus_match),
        .pin_iw  (cfg_in_narrow),
        .pin_ow  (cfg_out_narrow),
        .pin_lsb (cfg_lsb_first),
        .cfg     (cfg)
    );

    bmx_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .pk_valid (st_wr_valid),
        .pk_ready (st_wr_ready),
        .pk_data  (st_wr_data)
    );

    bmx_unpacker u_unpack (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .src_valid (st_rd_valid),
        .src_ready (st_rd_ready),
        .src_data  (st_rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/bmx_chk.sv
module bmx_chk
    import bmx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input bmx_cfg_t          cfg,
    input logic              in_valid,
    input logic              in_ready,
    input logic              st_wr_valid,
    input logic              st_wr_ready,
    input logic [WORD_W-1:0] st_wr_data,
    input logic              st_rd_valid,
    input logic              st_rd_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);

    logic [CNT_W-1:0] n_in, n_out, in_cnt, out_cnt;
    logic             in_hs, out_hs;

    assign n_in   = lanes_in(cfg.mode);
    assign n_out  = lanes_out(cfg.mode);
    assign in_hs  = in_valid && in_ready;
    assign out_hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_hs)
                in_cnt <= (in_cnt == n_in - CNT_W'(1)) ? '0 : in_cnt + CNT_W'(1);
            if (out_hs)
                out_cnt <= (out_cnt == n_out - CNT_W'(1)) ? '0 : out_cnt + CNT_W'(1);
        end
    end

    // R3
    pack_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_hs && in_cnt == n_in - CNT_W'(1)) |=> st_wr_valid);

    // R3
    pack_early_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_wr_valid) |-> $past(in_hs && in_cnt == n_in - CNT_W'(1)));

    // R4
    unpack_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (st_rd_ready && out_valid) |-> (out_ready && out_cnt == n_out - CNT_W'(1)));

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && n_out != CNT_W'(1)) |-> ((out_data & ~lane_mask(n_out, '0)) == '0));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_wr_valid && !st_wr_ready) |=> (st_wr_valid && $stable(st_wr_data)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !st_wr_valid));

endmodule

bind bmx_width_conv bmx_chk u_chk (.*);

// File: tb/sim_bmx_width_conv.sv
module sim_bmx_width_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p_bm = 0, p_iw = 0, p_ow = 0, p_lsb = 0;
    logic        in_valid = 0, st_wr_ready = 0, st_rd_valid = 0, out_ready = 0;
    logic [35:0] in_data = '0, st_rd_data = '0;
    logic        in_ready, st_wr_valid, st_rd_ready, out_valid;
    logic [35:0] st_wr_data, out_data;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    bmx_width_conv u0 (
        .clk(clk), .rst(rst),
        .cfg_bus_match(p_bm), .cfg_in_narrow(p_iw), .cfg_out_narrow(p_ow), .cfg_lsb_first(p_lsb),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready), .st_wr_data(st_wr_data),
        .st_rd_valid(st_rd_valid), .st_rd_ready(st_rd_ready), .st_rd_data(st_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1 width decode, computed independently
    function automatic int n_in_of(logic bm, logic iw, logic ow);
        return (bm && iw) ? (ow ? 4 : 2) : 1;
    endfunction
    function automatic int n_out_of(logic bm, logic iw, logic ow);
        return (bm && !iw) ? (ow ? 4 : 2) : 1;
    endfunction
    function automatic logic [35:0] low_mask(int w);
        return (36'h1 << w) - 36'h1;
    endfunction
    function automatic int lane_of(int k, int n, logic lsb);
        return lsb ? k : (n - 1 - k);
    endfunction
    function automatic logic [35:0] sub_val(int id, int j, int k, int w);
        longint v;
        v = longint'(id * 977 + j * 131 + k * 29 + 3) * 64'd40503 * 64'd1237;
        return 36'(v) & low_mask(w);
    endfunction
    function automatic logic [35:0] rd_word(int id, int j);
        longint v;
        v = longint'(id * 7 + j + 1) * 64'd2654435761;
        return 36'(v);
    endfunction
    function automatic logic [35:0] exp_packed(int id, int j, int n, logic lsb);
        logic [35:0] word;
        int w;
        w = 36 / n;
        word = '0;
        for (int k = 0; k < n; k++)
            word = word | (sub_val(id, j, k, w) << (lane_of(k, n, lsb) * w));
        return word;
    endfunction
    function automatic logic [35:0] exp_out(int id, int j, int k, int n, logic lsb);
        int w;
        w = 36 / n;
        return (rd_word(id, j) >> (lane_of(k, n, lsb) * w)) & low_mask(w);
    endfunction

    task automatic do_reset(logic bm, logic iw, logic ow, logic lsb);
        @(posedge clk); #1;
        rst = 1; p_bm = bm; p_iw = iw; p_ow = ow; p_lsb = lsb;
        in_valid = 0; st_rd_valid = 0; st_wr_ready = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
    endtask

    task automatic run_cfg(int id, logic bm, logic iw, logic ow, logic lsb);
        int ni, no, wi;
        bit mon_done;
        ni = n_in_of(bm, iw, ow);
        no = n_out_of(bm, iw, ow);
        wi = 36 / ni;
        mon_done = 0;
        do_reset(bm, iw, ow, lsb);
        @(negedge clk);
        check("R9 reset out_valid", {35'b0, out_valid}, 36'h0);
        check("R9 reset st_wr_valid", {35'b0, st_wr_valid}, 36'h0);
        if (ni > 1) begin
            // R9: one stray sub-word, then reset must drop it
            @(posedge clk); #1;
            in_valid = 1; in_data = 36'h123456789;
            @(posedge clk); #1;
            in_valid = 0;
            do_reset(bm, iw, ow, lsb);
        end
        // R2: scramble straps after reset
        @(posedge clk); #1;
        p_bm = ~bm; p_iw = ~iw; p_ow = ~ow; p_lsb = ~lsb;
        fork
            begin : writer
                for (int i = 0; i < 3 * ni; i++) begin
                    bit acc;
                    in_valid = 1;
                    // R6: garbage above the sub-word
                    in_data = (36'hABCDEF012 & ~low_mask(wi)) | sub_val(id, i / ni, i % ni, wi);
                    acc = 0;
                    while (!acc) begin
                        @(negedge clk); acc = in_ready;
                        @(posedge clk); #1;
                    end
                end
                in_valid = 0;
            end
            begin : source
                for (int j = 0; j < 3; j++) begin
                    bit acc;
                    st_rd_valid = 1;
                    st_rd_data  = rd_word(id, j);
                    acc = 0;
                    while (!acc) begin
                        @(negedge clk); acc = st_rd_ready;
                        @(posedge clk); #1;
                    end
                end
                st_rd_valid = 0;
            end
            begin : readies
                int ph;
                ph = 0;
                while (!mon_done) begin
                    st_wr_ready = (ph % 3) != 0;
                    out_ready   = (ph % 4) != 1;
                    ph++;
                    @(posedge clk); #1;
                end
            end
            begin : monitor
                int wr_seen, rd_seen;
                bit wr_stall, out_stall;
                logic [35:0] wr_prev, out_prev;
                wr_seen = 0; rd_seen = 0; wr_stall = 0; out_stall = 0;
                wr_prev = '0; out_prev = '0;
                while (wr_seen < 3 || rd_seen < 3 * no) begin
                    @(negedge clk);
                    if (wr_stall) begin
                        check("R8 st_wr_valid held", {35'b0, st_wr_valid}, 36'h1);
                        check("R8 st_wr_data held", st_wr_data, wr_prev);
                    end
                    if (out_stall) begin
                        check("R8 out_valid held", {35'b0, out_valid}, 36'h1);
                        check("R8 out_data held", out_data, out_prev);
                    end
                    if (st_wr_valid && st_wr_ready) begin
                        // R1 R2 R3 R5 R6 R10
                        check("R3/R5/R6 packed word", st_wr_data, exp_packed(id, wr_seen, ni, lsb));
                        wr_seen++;
                    end
                    if (out_valid && out_ready) begin
                        // R1 R4 R5 R7 R10
                        check("R4/R5/R7 output sub-word", out_data,
                              exp_out(id, rd_seen / no, rd_seen % no, no, lsb));
                        rd_seen++;
                    end
                    wr_stall  = st_wr_valid && !st_wr_ready;
                    out_stall = out_valid && !out_ready;
                    wr_prev   = st_wr_data;
                    out_prev  = out_data;
                end
                mon_done = 1;
            end
        join
        st_wr_ready = 1; out_ready = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 no extra packed word", {35'b0, st_wr_valid}, 36'h0);
        check("R4 no extra output sub-word", {35'b0, out_valid}, 36'h0);
    endtask

    initial begin
        int id;
        id = 0;
        for (int o = 0; o < 2; o++) begin
            run_cfg(id++, 0, 0, 0, o[0]);   // R10 36/36
            run_cfg(id++, 0, 1, 1, o[0]);   // R1 bus-match low overrides
            run_cfg(id++, 1, 0, 0, o[0]);   // 36 in / 18 out
            run_cfg(id++, 1, 0, 1, o[0]);   // 36 in / 9 out
            run_cfg(id++, 1, 1, 0, o[0]);   // 18 in / 36 out
            run_cfg(id++, 1, 1, 1, o[0]);   // 9 in / 36 out
        end
        summary();
        $finish;
    end

endmodule